// File: doc/BRIEF.md
# Switching-Cycle Fault Protection Sequencer

This block filters two protection comparators in a flyback controller. It judges them once per switching cycle and latches a shutdown when a fault persists. A strobe marks the end of demagnetization in each cycle. On that strobe the sampled output-overvoltage flag is counted toward a run of consecutive tripped cycles. The same strobe also resolves a two-strike overcurrent scheme: a first hit puts the block in a warning state, and a second hit in the very next cycle shuts it down.

The block also produces a blanking mask that hides the current-sense comparators for a fixed number of clocks after the gate rises. It turns the gate off at once on a peak-current-limit or overcurrent hit. A latched fault keeps the gate off until the supply is reported below its restart level. The latch is then released so the converter can try a fresh start.

Top module: `cycle_fault_seq`

## Requirements
- R1: While rst_ni is low and after its release with all inputs low, fault_o, gate_off_o and blank_o are 0.
- R2: blank_o is 1 during the clock in which gate_on_i is first seen high, and it stays 1 for LEB_CYC clocks in total while gate_on_i remains high. It is 0 whenever gate_on_i is low.
- R3: ilim_flag_i drives gate_off_o high in the same clock when gate_on_i is high and blank_o is 0. It has no effect while blank_o is 1.
- R4: ocp_flag_i drives gate_off_o high in the same clock when gate_on_i is high and blank_o is 0. A flag seen only while blank_o is 1 does not count as an overcurrent hit.
- R5: fault_o rises at the clock edge of the OVP_CNT-th consecutive strobe (cyc_end_i high) that samples ovp_flag_i high. ovp_flag_i is only sampled on strobe clocks.
- R6: A strobe that samples ovp_flag_i low restarts the consecutive overvoltage count from zero.
- R7: A cycle with an overcurrent hit, closed by its strobe, enters the warning state without setting fault_o. If the following cycle has no hit, the block returns to idle, and a later single hit again only warns.
- R8: Overcurrent hits in two consecutive cycles set fault_o at the second cycle's strobe.
- R9: While fault_o is 1, gate_off_o is 1 and fault_o holds whatever the other inputs do. A clock with vdd_low_i high clears fault_o at that edge.
- R10: While the fault is latched, the overvoltage count and the overcurrent warning are held at zero. After release, a full new run of OVP_CNT tripped strobes is needed to shut down again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_end_i | input | 1 | One-clock strobe at the end of demagnetization |
| ovp_flag_i | input | 1 | Sampled output overvoltage comparator result |
| ocp_flag_i | input | 1 | Overcurrent (hiccup level) comparator |
| ilim_flag_i | input | 1 | Peak-current limit comparator |
| gate_on_i | input | 1 | Current gate drive state |
| vdd_low_i | input | 1 | Supply is below the restart level |
| gate_off_o | output | 1 | Request to turn the gate off now |
| fault_o | output | 1 | Latched shutdown |
| blank_o | output | 1 | Leading-edge blanking mask for current sense |

## Verification
A wrong overvoltage count becomes visible only at a strobe. It shows as fault_o rising one cycle early or late, or never, after a clean cycle should have restarted the run. A warning state that is stuck or lost shows up the same way, at the strobe of the next hit cycle, as a missing or spurious shutdown. A bad blanking counter shows within a few clocks after the gate rises, through blank_o and through gate_off_o answering a current flag too early or too late. A latch that leaks shows the clock after a strobe, and a latch that fails to release shows the clock after vdd_low_i.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic {
    OC_IDLE = 1'b0,
    OC_WARN = 1'b1
  } oc_state_e;
endpackage

// File: rtl/fsp_leb.sv
module fsp_leb #(
  parameter int unsigned LEB_CYC = 95
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_on_i,
  output logic blank_o
);
  localparam int unsigned CW = $clog2(LEB_CYC + 1);

  logic          gate_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise    = gate_on_i & ~gate_q;
  assign blank_o = gate_on_i & (rise | (cnt_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_on_i;
      if (!gate_on_i)        cnt_q <= '0;
      else if (rise)         cnt_q <= CW'(LEB_CYC - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  leb_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LEB_CYC));

  generate
    if (LEB_CYC > 1) begin : g_hold_chk
      // R2
      leb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && gate_on_i) |=> (gate_on_i -> blank_o));
    end
  endgenerate
endmodule

// File: rtl/fsp_ovp.sv
module fsp_ovp #(
  parameter int unsigned OVP_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic ovp_i,
  input  logic hold_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(OVP_CNT + 1);

  logic [CW-1:0] run_q;

  assign trip_o = strobe_i & ovp_i & ~hold_i & (run_q == CW'(OVP_CNT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (hold_i)             run_q <= '0;
    else if (strobe_i) begin
      if (!ovp_i || trip_o)      run_q <= '0;
      else                       run_q <= run_q + 1'b1;
    end
  end

  // R5
  ovp_run_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < CW'(OVP_CNT));

  // R6
  ovp_clean_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !ovp_i) |=> (run_q == '0));

  // R10
  ovp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (run_q == '0));
endmodule

// File: rtl/fsp_ocp.sv
module fsp_ocp
  import fsp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic ocp_i,
  input  logic hold_i,
  output logic trip_o
);
  oc_state_e state_q;
  logic      seen_q;
  logic      hit;

  assign hit    = seen_q | ocp_i;
  assign trip_o = strobe_i & hit & ~hold_i & (state_q == OC_WARN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OC_IDLE;
      seen_q  <= 1'b0;
    end else if (hold_i) begin
      state_q <= OC_IDLE;
      seen_q  <= 1'b0;
    end else if (strobe_i) begin
      state_q <= (hit && state_q == OC_IDLE) ? OC_WARN : OC_IDLE;
      seen_q  <= 1'b0;
    end else if (ocp_i) begin
      seen_q  <= 1'b1;
    end
  end

  // R7
  ocp_warn_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OC_WARN && strobe_i && !hit) |=> (state_q == OC_IDLE));

  // R7
  ocp_warn_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OC_IDLE && strobe_i && hit && !hold_i) |=> (state_q == OC_WARN));

  // R10
  ocp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (state_q == OC_IDLE && !seen_q));
endmodule

// File: rtl/cycle_fault_seq.sv
module cycle_fault_seq #(
  parameter int unsigned OVP_CNT = 4,
  parameter int unsigned LEB_CYC = 95
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_end_i,
  input  logic ovp_flag_i,
  input  logic ocp_flag_i,
  input  logic ilim_flag_i,
  input  logic gate_on_i,
  input  logic vdd_low_i,
  output logic gate_off_o,
  output logic fault_o,
  output logic blank_o
);
  logic blank;
  logic ocp_eff, ilim_eff;
  logic ovp_trip, ocp_trip;
  logic fault_q;

  fsp_leb #(.LEB_CYC(LEB_CYC)) u_leb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_on_i (gate_on_i),
    .blank_o   (blank)
  );

  // current-sense flags only count with the gate on and outside blanking
  assign ocp_eff  = ocp_flag_i  & gate_on_i & ~blank;
  assign ilim_eff = ilim_flag_i & gate_on_i & ~blank;

  fsp_ovp #(.OVP_CNT(OVP_CNT)) u_ovp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cyc_end_i),
    .ovp_i    (ovp_flag_i),
    .hold_i   (fault_q),
    .trip_o   (ovp_trip)
  );

  fsp_ocp u_ocp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cyc_end_i),
    .ocp_i    (ocp_eff),
    .hold_i   (fault_q),
    .trip_o   (ocp_trip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   fault_q <= 1'b0;
    else if (vdd_low_i)            fault_q <= 1'b0;
    else if (ovp_trip || ocp_trip) fault_q <= 1'b1;
  end

  assign fault_o    = fault_q;
  assign blank_o    = blank;
  assign gate_off_o = fault_q | ocp_eff | ilim_eff;

  // R9
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !vdd_low_i) |=> fault_o);

  // R9
  fault_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdd_low_i |=> !fault_o);

  // R4
  ocp_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_flag_i && gate_on_i && !blank_o) |-> gate_off_o);

  // R3
  ilim_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilim_flag_i && gate_on_i && !blank_o) |-> gate_off_o);

  // R9
  fault_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> gate_off_o);
endmodule

// File: tb/cycle_fault_seq_test.sv
module cycle_fault_seq_test;
  localparam int unsigned OVP_N = 4;
  localparam int unsigned LEB_N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_end = 1'b0, ovp = 1'b0, ocp = 1'b0, ilim = 1'b0, gate = 1'b0, vdd_low = 1'b0;
  logic gate_off, fault, blank;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    f;
    bit    o;
    bit    b;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  cycle_fault_seq #(.OVP_CNT(OVP_N), .LEB_CYC(LEB_N)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cyc_end_i   (cyc_end),
    .ovp_flag_i  (ovp),
    .ocp_flag_i  (ocp),
    .ilim_flag_i (ilim),
    .gate_on_i   (gate),
    .vdd_low_i   (vdd_low),
    .gate_off_o  (gate_off),
    .fault_o     (fault),
    .blank_o     (blank)
  );

  task automatic cmp(bit f, bit o, bit b, string tag);
    checks++;
    if (fault !== f || gate_off !== o || blank !== b) begin
      errors++;
      $display("FAIL %s: fault/off/blank got %b%b%b expected %b%b%b",
               tag, fault, gate_off, blank, f, o, b);
    end
  endtask

  // monitor: outputs after each edge, inputs still held
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.f, e.o, e.b, e.tag);
      end
    end
  end

  task automatic step(bit s, bit ov, bit oc, bit il, bit g, bit vl,
                      bit ef, bit eo, bit eb, string tag);
    @(negedge clk);
    cyc_end = s; ovp = ov; ocp = oc; ilim = il; gate = g; vdd_low = vl;
    exp_q.push_back('{ef, eo, eb, tag});
  endtask

  // one switching cycle: 5 gate clocks, then the strobe with the gate low
  task automatic run_cycle(bit ov_end, bit ov_mid, bit oc, bit ef, string tag);
    for (int i = 0; i < 3; i++) step(0, ov_mid, 0, 0, 1, 0, 0, 0, 1, tag);
    step(0, ov_mid, oc, 0, 1, 0, 0, oc, 0, tag);
    step(0, ov_mid, oc, 0, 1, 0, 0, oc, 0, tag);
    step(1, ov_end, 0, 0, 0, 0, ef, ef, 0, tag);
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    cmp(0, 0, 0, "R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after reset");

    // R2 blanking window
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 1, "R2 window");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R2 window end");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R2 window end");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 gate low");

    // R3 peak limit masked in blanking, acts at once afterwards
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 0, 0, 0, 1, "R3 blanked");
    step(0, 0, 0, 1, 1, 0, 0, 1, 0, "R3 limit");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 gate low");

    // R4 overcurrent only inside blanking: no hit
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, 0, 0, 0, 1, "R4 blanked");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R4 blanked");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R4 blanked");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 blanked strobe");

    // R7 warn, clean cycle, warn again, then R8 second strike
    run_cycle(0, 0, 1, 0, "R7 first hit");
    run_cycle(0, 0, 0, 0, "R7 clean");
    run_cycle(0, 0, 1, 0, "R7 single hit");
    run_cycle(0, 0, 1, 1, "R8 second hit");

    // R9 latch holds, then releases on low supply
    step(1, 1, 1, 1, 0, 0, 1, 1, 0, "R9 hold");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R9 hold");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 release");

    // R5/R6 overvoltage run
    for (int i = 0; i < 3; i++) run_cycle(1, 0, 0, 0, "R5 run");
    run_cycle(0, 1, 0, 0, "R6 clean strobe");
    for (int i = 0; i < 3; i++) run_cycle(1, 0, 0, 0, "R6 restarted");
    run_cycle(1, 0, 0, 1, "R5 fourth");

    // R10 counts held at zero while latched
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, 1, 1, 0, "R10 latched");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 release");
    for (int i = 0; i < 3; i++) run_cycle(1, 0, 0, 0, "R10 fresh run");
    run_cycle(1, 0, 0, 1, "R10 fresh trip");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9 release");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule